// File: doc/BRIEF.md
# Phase-Accumulator Paced Serial Transmitter

This block drives an asynchronous serial line from a stream of bytes. Its bit clock is not a divided copy of the system clock. A phase accumulator adds a 16-bit increment on every clock, and each carry out of its top bit is a tick. One tick marks one bit time, so the line rate is the increment times the clock frequency divided by two to the accumulator width. The default width is 20 bits.

Each byte leaves as a ten-bit frame: a low start bit, the data bits least significant first, and a high stop bit. The line rests high between frames. A 32-bit control word holds the enable, the increment and several option bits. The option bits are kept only so that they read back; they have no effect on the line. A byte is taken from the valid/ready stream only on a tick while transmission is enabled. A frame that has begun always runs to its end.

Top module: `nco_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `s_ready` is 0 and `ctrl_rdata` is 0.
- R2: A frame is one low start bit, then the 8 data bits starting with bit 0, then one high stop bit.
- R3: Ticks are the carries of an ACC_W-bit accumulator that adds the increment in `ctrl_rdata[31:16]` on every clock, and each line bit lasts one tick period. Ten consecutive bits therefore span floor or ceil of 10·2^ACC_W/increment clocks.
- R4: While the enable bit (bit 0) is 0, `s_ready` stays 0 and no new frame starts.
- R5: Clearing the enable bit during a frame does not cut that frame short, and no further frame follows.
- R6: With an increment of 0, no tick occurs, `s_ready` stays 0 and `txd` stays 1.
- R7: A write stores bits 31:16, 9:4 and 2:0 of `ctrl_wdata`, and `ctrl_rdata` returns them. Bit 3 and bits 15:10 read as 0.
- R8: Control bits 1, 2 and 4 to 9 do not change the transmitted frames.
- R9: A byte held valid when a stop bit ends gets its start bit at that tick, with no idle bit between the frames.
- R10: Each accepted byte is sent exactly once, in the order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Stored control word |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | DATA_W | Byte stream data |
| s_ready | output | 1 | Byte taken at this clock edge when valid |
| txd | output | 1 | Serial line output, idles high |

## Verification
The bench builds the block with ACC_W = 17 instead of 20. This shrinks a bit period to 8 to 40 clocks for increments between about 3300 and 16000. Many frames, back-to-back bursts and a mid-frame disable then fit in a short run. It also keeps the floor/ceil window on the ten-bit span tight enough to catch an accumulator that is off by one bit of width.

// File: rtl/nco_uart_pkg.sv
package nco_uart_pkg;
  localparam int CTRL_W   = 32;
  localparam int INC_W    = 16;
  localparam int INC_LSB  = 16;
  localparam int EN_BIT   = 0;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 32'hFFFF_03F7;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/nco_uart_ctrl.sv
module nco_uart_ctrl
  import nco_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              tx_en,
  output logic [INC_W-1:0]  inc
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) ctrl_d = wdata & CTRL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign tx_en = ctrl_q[EN_BIT];
  assign inc   = ctrl_q[INC_LSB +: INC_W];

  // R7: contents change only through a write
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl_q));
endmodule

// File: rtl/nco_uart_nco.sv
module nco_uart_nco #(
  parameter int INC_W = 16,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic             tick
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             tick_q, tick_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = {1'b0, acc_q} + SUM_W'(inc);
    acc_d  = sum[ACC_W-1:0];
    tick_d = sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R6: a zero increment never yields a tick
  a_r6_zero_inc_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0) |=> !tick);
endmodule

// File: rtl/nco_uart_shift.sv
module nco_uart_shift
  import nco_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              txd
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic              txd_q, txd_d;
  logic              last_bit;
  logic              take;

  assign last_bit = (state_q == TX_SEND) && (cnt_q == LAST_CNT);
  assign s_ready  = tx_en && tick && ((state_q == TX_IDLE) || last_bit);
  assign take     = s_valid && s_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    txd_d   = txd_q;
    if (tick) begin
      if (take) begin
        state_d = TX_SEND;
        cnt_d   = '0;
        sh_d    = {1'b1, s_data};
        txd_d   = 1'b0;
      end else if (state_q == TX_SEND) begin
        if (last_bit) begin
          state_d = TX_IDLE;
          txd_d   = 1'b1;
        end else begin
          txd_d   = sh_q[0];
          sh_d    = {1'b1, sh_q[DATA_W:1]};
          cnt_d   = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '1;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      txd_q   <= txd_d;
    end
  end

  assign txd = txd_q;

  // R1: the line rests high outside a frame
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> txd_q);
  // R2: the final bit of a frame is high
  a_r2_stop_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> txd_q);
  // R4: a start bit begins only while enabled
  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd_q) && state_q == TX_SEND && cnt_q == '0) |-> $past(tx_en));
  // R5: an unfinished frame keeps going
  a_r5_frame_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SEND && !last_bit) |=> (state_q == TX_SEND));
endmodule

// File: rtl/nco_uart_tx.sv
module nco_uart_tx
  import nco_uart_pkg::*;
#(
  parameter int ACC_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  output logic [31:0]       ctrl_rdata,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              txd
);
  logic             tx_en;
  logic [INC_W-1:0] inc;
  logic             tick;

  nco_uart_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ctrl_we),
    .wdata  (ctrl_wdata),
    .ctrl_q (ctrl_rdata),
    .tx_en  (tx_en),
    .inc    (inc)
  );

  nco_uart_nco #(.INC_W(INC_W), .ACC_W(ACC_W)) u_nco (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc),
    .tick  (tick)
  );

  nco_uart_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .tx_en   (tx_en),
    .s_valid (s_valid),
    .s_data  (s_data),
    .s_ready (s_ready),
    .txd     (txd)
  );
endmodule

// File: tb/nco_uart_tx_bench.sv
module nco_uart_tx_bench;
  localparam int ACC  = 17;
  localparam int FULL = 1 << ACC;
  localparam logic [31:0] KEEP = 32'hFFFF_03F7;

  logic        clk;
  logic        rst_n;
  logic        ctrl_we;
  logic [31:0] ctrl_wdata;
  logic [31:0] ctrl_rdata;
  logic        s_valid;
  logic [7:0]  s_data;
  logic        s_ready;
  logic        txd;

  nco_uart_tx #(.ACC_W(ACC), .DATA_W(8)) u_nco_uart_tx (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .txd(txd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int unsigned vecs = 0;
  int unsigned bad  = 0;
  int cyc = 0;
  int cur_inc = 0;
  int ready_seen = 0;
  int low_seen = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int t_q[$];

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (s_ready) ready_seen++;
    if (txd !== 1'b1) low_seen++;
  end

  task automatic chk(bit ok, string req, longint act, longint expv);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // line decoder: samples each bit at its nominal centre
  initial begin : mon
    int t0;
    int off;
    logic [7:0] b;
    logic st;
    logic sp;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0 && cur_inc != 0) begin
        t0 = cyc;
        b  = '0;
        st = 1'b1;
        sp = 1'b0;
        for (int k = 0; k < 10; k++) begin
          off = ((2 * k + 1) * FULL) / (2 * cur_inc);
          while (cyc < t0 + off) @(negedge clk);
          if (k == 0)      st = txd;
          else if (k == 9) sp = txd;
          else             b[k-1] = txd;
        end
        chk(st == 1'b0, "R2 start bit", st, 0);
        chk(sp == 1'b1, "R2 stop bit", sp, 1);
        got_q.push_back(b);
        t_q.push_back(t0);
      end
    end
  end

  task automatic wr_ctrl(logic [31:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // caller is at a negedge
  task automatic send(logic [7:0] d);
    s_data  = d;
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic drain(int n, string req);
    int w;
    w = 0;
    while (got_q.size() < n && w < 20000) begin
      @(negedge clk);
      w++;
    end
    repeat (2 * FULL / cur_inc + 4) @(negedge clk);
    chk(got_q.size() == n, req, got_q.size(), n);
  endtask

  task automatic compare_bytes(string req);
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
  endtask

  task automatic check_spans(bit tight);
    int lo;
    int hi;
    int gap;
    lo = (10 * FULL) / cur_inc;
    hi = lo + (((10 * FULL) % cur_inc) != 0 ? 1 : 0);
    for (int i = 1; i < t_q.size(); i++) begin
      gap = t_q[i] - t_q[i-1];
      chk(gap >= lo, "R3 ten-bit span lower bound", gap, lo);
      if (tight) chk(gap <= hi, "R9 back-to-back span", gap, hi);
    end
  endtask

  task automatic clear_q();
    got_q.delete();
    exp_q.delete();
    t_q.delete();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    vecs++;
    bad++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    int inc;
    int n;
    logic [31:0] v;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0;
    ctrl_we = 1'b0;
    ctrl_wdata = '0;
    s_valid = 1'b0;
    s_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd after reset", txd, 1);
    chk(s_ready == 1'b0, "R1 s_ready after reset", s_ready, 0);
    chk(ctrl_rdata == 32'd0, "R1 ctrl after reset", ctrl_rdata, 0);

    // R6: enabled but zero increment
    wr_ctrl(32'h0000_0001);
    ready_seen = 0;
    low_seen = 0;
    s_data = 8'h5A;
    s_valid = 1'b1;
    repeat (600) @(negedge clk);
    s_valid = 1'b0;
    chk(ready_seen == 0, "R6 ready with zero increment", ready_seen, 0);
    chk(low_seen == 0, "R6 line with zero increment", low_seen, 0);

    // R4: increment set, enable clear
    cur_inc = 8000;
    wr_ctrl(32'd8000 << 16);
    ready_seen = 0;
    low_seen = 0;
    s_valid = 1'b1;
    repeat (600) @(negedge clk);
    s_valid = 1'b0;
    chk(ready_seen == 0, "R4 ready while disabled", ready_seen, 0);
    chk(low_seen == 0, "R4 line while disabled", low_seen, 0);

    // R7: stored bits read back, others zero
    wr_ctrl(32'hFFFF_FFFF);
    @(negedge clk);
    chk(ctrl_rdata == KEEP, "R7 all-ones readback", ctrl_rdata, KEEP);
    for (int i = 0; i < 4; i++) begin
      v = $urandom;
      wr_ctrl(v);
      chk(ctrl_rdata == (v & KEEP), "R7 random readback", ctrl_rdata, v & KEEP);
    end
    wr_ctrl(32'd0);
    repeat (4) @(negedge clk);
    clear_q();

    // R2 R8 R10 R3: random increments, option bits and bytes
    for (int c = 0; c < 6; c++) begin
      inc = 3300 + int'($urandom % 12700);
      v = (32'(inc) << 16) | ($urandom & 32'h0000_03F6) | 32'h1;
      cur_inc = inc;
      wr_ctrl(v);
      n = 1 + int'($urandom % 4);
      @(negedge clk);
      for (int j = 0; j < n; j++) begin
        send(8'($urandom));
        repeat ($urandom % 30) @(negedge clk);
      end
      drain(n, "R10 frame count");
      compare_bytes("R8 R2 decoded byte");
      check_spans(1'b0);
      wr_ctrl(v & 32'hFFFF_FFFE);
      clear_q();
    end

    // R2 directed patterns with all option bits set
    cur_inc = 4096;
    wr_ctrl((32'd4096 << 16) | 32'h0000_03F7);
    @(negedge clk);
    send(8'h00);
    send(8'hFF);
    send(8'h01);
    send(8'h80);
    drain(4, "R10 directed count");
    compare_bytes("R2 directed byte");
    check_spans(1'b1);
    clear_q();

    // R9: back-to-back burst
    cur_inc = 6000;
    wr_ctrl((32'd6000 << 16) | 32'h1);
    @(negedge clk);
    for (int j = 0; j < 5; j++) send(8'h30 + 8'(j * 17));
    drain(5, "R9 burst count");
    compare_bytes("R9 burst byte");
    check_spans(1'b1);
    clear_q();

    // R5: disable during a frame
    cur_inc = 5000;
    wr_ctrl((32'd5000 << 16) | 32'h1);
    @(negedge clk);
    send(8'hC3);
    repeat (3 * FULL / 5000) @(negedge clk);
    wr_ctrl(32'd5000 << 16);
    ready_seen = 0;
    s_data = 8'h11;
    s_valid = 1'b1;
    drain(1, "R5 frames after disable");
    repeat (12 * FULL / 5000) @(negedge clk);
    s_valid = 1'b0;
    compare_bytes("R5 frame finished after disable");
    chk(got_q.size() == 1, "R5 no frame after disable", got_q.size(), 1);
    chk(ready_seen == 0, "R4 ready after disable", ready_seen, 0);
    chk(txd == 1'b1, "R1 line idle at end", txd, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule